// File: doc/BRIEF.md
# Zone Write Permission Filter

This block sits between a memory command decoder and a nonvolatile byte array. For every byte write aimed at a user zone it decides whether the write may proceed and which bits may change. The decoder presents the request (address, data, first-byte marker), the policy of the zone being written, the byte currently stored at the target address and the lock byte of the addressed page. One cycle later the block either pulses a commit strobe with the data to store, or raises a rejection flag, or stays silent.

There are four zone policies. An open zone takes data as given. A program-only zone can only clear bits. A frozen zone refuses every write. A page-locked zone treats the lowest byte of each 8-byte page as a per-byte write-enable mask for that page. That mask byte can only be cleared bit by bit, and it freezes itself once its own bit 0 is cleared. In a page-locked zone, only the first byte of a multi-byte command is used. The block also computes the lock-byte address of the request's page, so that the decoder can fetch it.

Top module: `zone_write_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `commit_valid` and `reject` are 0.
- R2: With `zone_policy` = 0 (open), a valid request yields, one clock later, `commit_valid` = 1, `commit_data` equal to `req_data` and `commit_addr` equal to `req_addr`.
- R3: With `zone_policy` = 1 (program-only), a valid request commits `old_data & req_data` one clock later, so no stored bit can go from 0 to 1.
- R4: With `zone_policy` = 2 (frozen), a valid request yields `reject` = 1 and `commit_valid` = 0 one clock later.
- R5: With `zone_policy` = 3 (page-locked) and `req_first` = 1, the page offset is `req_addr[2:0]`. The output `lock_addr` is `req_addr` with bits [2:0] cleared, and it is valid combinationally. For offsets 1 to 7, bit *offset* of `lock_byte` being 0 rejects the write, and being 1 commits `req_data` unchanged.
- R6: In page-locked mode, a write to offset 0 (the lock byte) with `lock_byte[0]` = 1 commits `old_data & req_data`.
- R7: In page-locked mode, a write to offset 0 with `lock_byte[0]` = 0 is rejected.
- R8: In page-locked mode, a request with `req_first` = 0 (a later byte of the same command) produces neither a commit nor a rejection.
- R9: A cycle with `req_valid` = 0 produces neither a commit nor a rejection in the next cycle.
- R10: `commit_valid` and `reject` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A byte write request is present |
| req_first | input | 1 | 1 for the first byte of a command |
| req_addr | input | ADDR_W | Byte address within the zone |
| req_data | input | DATA_W | Byte the host wants to write |
| zone_policy | input | 2 | 0 open, 1 program-only, 2 frozen, 3 page-locked |
| old_data | input | DATA_W | Byte currently stored at `req_addr` |
| lock_byte | input | DATA_W | Stored byte at `lock_addr` |
| lock_addr | output | ADDR_W | Address of the lock byte of the request's page |
| commit_valid | output | 1 | Strobe: write `commit_data` at `commit_addr` |
| commit_addr | output | ADDR_W | Address to write |
| commit_data | output | DATA_W | Filtered data to store |
| reject | output | 1 | The request was refused |

## Verification
The hardest cases to reach are the lock-byte corner cases. A write to offset 0 must be filtered by the lock byte's own bit 0, and it must also be restricted to clearing bits. A later byte of a page-locked command must vanish without any response. The stimulus sweeps all 256 lock-byte values against every page offset, every policy and both states of the first-byte marker. Two data patterns are used that are derived from the lock value, so that cleared and set bits appear in every position. Each response is checked against a model computed in the bench.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

   typedef enum logic [1:0] {
      POL_OPEN   = 2'd0,
      POL_PROG   = 2'd1,
      POL_FROZEN = 2'd2,
      POL_LOCKED = 2'd3
   } zone_policy_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_COMMIT = 2'd1,
      ACT_REJECT = 2'd2
   } wr_action_e;

endpackage

// File: rtl/wlf_page_index.sv
module wlf_page_index #(
   parameter int ADDR_W = 10,
   parameter int OFF_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] page_base,
   output logic              is_head
);
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("wlf_page_index: ADDR_W must exceed OFF_W");
   end

   always_comb begin
      offset    = addr[OFF_W-1:0];
      page_base = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      is_head   = (addr[OFF_W-1:0] == '0);
   end
endmodule

// File: rtl/wlf_policy_eval.sv
module wlf_policy_eval
   import wlf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFF_W  = 3
) (
   input  logic              valid,
   input  logic              first,
   input  zone_policy_e      policy,
   input  logic [OFF_W-1:0]  offset,
   input  logic              is_head,
   input  logic [DATA_W-1:0] mask_byte,
   input  logic [DATA_W-1:0] stored,
   input  logic [DATA_W-1:0] incoming,
   output wr_action_e        action,
   output logic [DATA_W-1:0] result
);
   localparam int SLOTS = 1 << OFF_W;

   if (SLOTS != DATA_W) begin : g_bad_mask
      $error("wlf_policy_eval: lock byte width must equal page size");
   end

   logic [DATA_W-1:0] cleared_only;
   logic              slot_open;

   always_comb begin
      cleared_only = stored & incoming;
      slot_open    = mask_byte[offset];
   end

   always_comb begin
      action = ACT_NONE;
      result = incoming;
      if (valid) begin
         unique case (policy)
            POL_OPEN: begin
               action = ACT_COMMIT;
            end
            POL_PROG: begin
               action = ACT_COMMIT;
               result = cleared_only;
            end
            POL_FROZEN: begin
               action = ACT_REJECT;
            end
            POL_LOCKED: begin
               if (!first) begin
                  action = ACT_NONE;
               end else if (!slot_open) begin
                  action = ACT_REJECT;
               end else begin
                  action = ACT_COMMIT;
                  if (is_head) result = cleared_only;
               end
            end
            default: action = ACT_NONE;
         endcase
      end
   end
endmodule

// File: rtl/wlf_out_stage.sv
module wlf_out_stage
   import wlf_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_action_e        action,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              commit_valid,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic              reject
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            commit_valid <= 1'b0;
            reject       <= 1'b0;
            commit_addr  <= '0;
            commit_data  <= '0;
         end else begin
            commit_valid <= (action == ACT_COMMIT);
            reject       <= (action == ACT_REJECT);
            commit_addr  <= addr_in;
            commit_data  <= data_in;
         end
      end
   end else begin : g_comb
      always_comb begin
         commit_valid = rst_n && (action == ACT_COMMIT);
         reject       = rst_n && (action == ACT_REJECT);
         commit_addr  = addr_in;
         commit_data  = data_in;
      end
   end
endmodule

// File: rtl/zone_write_filter.sv
module zone_write_filter
   import wlf_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_first,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [1:0]        zone_policy,
   input  logic [DATA_W-1:0] old_data,
   input  logic [DATA_W-1:0] lock_byte,
   output logic [ADDR_W-1:0] lock_addr,
   output logic              commit_valid,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic              reject
);
   localparam int OFF_W = $clog2(DATA_W);

   if (DATA_W < 2 || (1 << OFF_W) != DATA_W) begin : g_bad_data
      $error("zone_write_filter: DATA_W must be a power of two >= 2");
   end

   logic [OFF_W-1:0] offset;
   logic             is_head;
   wr_action_e       action;
   logic [DATA_W-1:0] filtered;
   zone_policy_e     policy;

   assign policy = zone_policy_e'(zone_policy);

   wlf_page_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_index (
      .addr      (req_addr),
      .offset    (offset),
      .page_base (lock_addr),
      .is_head   (is_head)
   );

   wlf_policy_eval #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_eval (
      .valid     (req_valid),
      .first     (req_first),
      .policy    (policy),
      .offset    (offset),
      .is_head   (is_head),
      .mask_byte (lock_byte),
      .stored    (old_data),
      .incoming  (req_data),
      .action    (action),
      .result    (filtered)
   );

   wlf_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .action       (action),
      .addr_in      (req_addr),
      .data_in      (filtered),
      .commit_valid (commit_valid),
      .commit_addr  (commit_addr),
      .commit_data  (commit_data),
      .reject       (reject)
   );

   if (OUT_REG) begin : g_chk
      assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !(commit_valid && reject));

      assert_open_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && zone_policy == 2'd0) |=>
            (commit_valid && commit_data == $past(req_data)
             && commit_addr == $past(req_addr)));

      assert_prog_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && zone_policy == 2'd1) |=>
            (commit_valid && (commit_data & ~$past(old_data)) == '0));

      assert_frozen_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && zone_policy == 2'd2) |=> (reject && !commit_valid));

      assert_head_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_first && zone_policy == 2'd3 && req_addr == lock_addr) |=>
            (!commit_valid || (commit_data & ~$past(old_data)) == '0));

      assert_tail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_first && zone_policy == 2'd3) |=> (!commit_valid && !reject));

      assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!commit_valid && !reject));
   end
endmodule

// File: tb/tb_zone_write_filter.sv
module tb_zone_write_filter;
   localparam int AW = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_first;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data, old_data, lock_byte;
   logic [1:0]    zone_policy;
   logic [AW-1:0] lock_addr, commit_addr;
   logic          commit_valid, reject;
   logic [DW-1:0] commit_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   zone_write_filter #(.ADDR_W(AW), .DATA_W(DW), .OUT_REG(1'b1)) dut (
      .clk, .rst_n, .req_valid, .req_first, .req_addr, .req_data,
      .zone_policy, .old_data, .lock_byte, .lock_addr,
      .commit_valid, .commit_addr, .commit_data, .reject
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_first = 1'b0; req_addr = '0;
      req_data = '0; old_data = '0; lock_byte = '0; zone_policy = 2'd0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet while in reset
      check(!commit_valid && !reject, "R1", "reset outputs",
            {commit_valid, reject}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!commit_valid && !reject, "R1", "first cycle after reset",
            {commit_valid, reject}, 0);

      for (int pol = 0; pol < 4; pol++) begin
         for (int off = 0; off < 8; off++) begin
            for (int f = 0; f < 2; f++) begin
               for (int lk = 0; lk < 256; lk++) begin
                  for (int k = 0; k < 2; k++) begin
                     logic [DW-1:0] nd, od, ed;
                     logic [AW-1:0] ad;
                     bit ec, er;
                     string tag;
                     nd = (k == 0) ? (lk[7:0] ^ 8'hC3) : {lk[3:0], ~lk[7:4]};
                     od = (off == 0) ? lk[7:0] : (lk[7:0] ^ 8'h3C);
                     ad = {lk[6:0], off[2:0]};
                     ec = 1'b0; er = 1'b0; ed = nd;
                     case (pol)
                        0: begin ec = 1'b1; tag = "R2"; end
                        1: begin ec = 1'b1; ed = od & nd; tag = "R3"; end
                        2: begin er = 1'b1; tag = "R4"; end
                        default: begin
                           if (f == 0) tag = "R8";
                           else if (off == 0) begin
                              tag = lk[0] ? "R6" : "R7";
                              if (lk[0]) begin ec = 1'b1; ed = od & nd; end
                              else er = 1'b1;
                           end else begin
                              tag = "R5";
                              if (lk[off]) ec = 1'b1; else er = 1'b1;
                           end
                        end
                     endcase
                     req_valid = 1'b1; req_first = f[0]; req_addr = ad;
                     req_data = nd; old_data = od; lock_byte = lk[7:0];
                     zone_policy = pol[1:0];
                     #1;
                     check(lock_addr == {ad[AW-1:3], 3'b000}, "R5", "lock_addr",
                           32'(lock_addr), 32'({ad[AW-1:3], 3'b000}));
                     @(negedge clk);
                     check(commit_valid == ec && reject == er, tag, "strobe/reject",
                           {commit_valid, reject}, {ec, er});
                     check(!(commit_valid && reject), "R10", "exclusive",
                           {commit_valid, reject}, 0);
                     if (ec) begin
                        check(commit_data == ed && commit_addr == ad, tag, "data/addr",
                              {commit_addr, commit_data}, {ad, ed});
                     end
                  end
               end
            end
         end
      end

      // R9: idle cycles with lively inputs produce nothing
      for (int i = 0; i < 16; i++) begin
         req_valid = 1'b0; req_first = 1'b1; zone_policy = i[1:0];
         req_addr = AW'(i * 37); req_data = 8'(i * 29); lock_byte = 8'hFF;
         @(negedge clk);
         check(!commit_valid && !reject, "R9", "idle",
               {commit_valid, reject}, 0);
      end

      done = 1'b1;
      finish_run();
   end
endmodule